// File: doc/BRIEF.md
# Multiplexed bus cycle timing generator

This block runs one bus cycle at a time on lines that carry the address first and the data afterwards. A requester presents a cycle kind (read, write or interrupt acknowledge), a memory/IO flag, an address and write data. The block then steps through the T-states T1, T2, T3, any number of wait states (TW) and T4. It drives the address latch strobe, the active-low write and interrupt-acknowledge strobes, the active-low transceiver enable, the direction and memory/IO select lines, and the shared bus together with its output enable. Read data is captured from the bus at the end of the final T3 or TW state.

The block is clocked at twice the bus rate. Every T-state spans two `clk` periods: a first half (phase 0) and a second half (phase 1). Every output is a register, so a strobe can change in the middle of a T-state. Another bus master may take the bus through a hold request. The block then floats the bus and its control lines at the same moment that it raises the hold acknowledge. It takes the bus back after the request is withdrawn.

Top module: `bus_cycle_seq`

## Requirements
- R1: During both halves of T1 `ale` is high, `ad_oe` is high and `ad_out` carries the request address. `ale` is low in every other state. T1 is always followed by T2.
- R2: In a write cycle `ad_oe` is high and `ad_out` carries the write data from T2 through the end of T4. In read and interrupt-acknowledge cycles, in idle states and during hold, `ad_oe` is low outside T1.
- R3: `wr_n` is low in both halves of T2, T3 and every TW of a write cycle, and high at all other times.
- R4: `inta_n` is low in both halves of T2, T3 and every TW of an interrupt-acknowledge cycle (kind code 2'b10), and high at all other times.
- R5: `den_n` is low from the second half of T2 through the first half of T4 for read and interrupt-acknowledge cycles. For write cycles it is low from the first half of T2 through the first half of T4.
- R6: `ready` is sampled at the end of the second half of T3 and of each TW. When it is low, another TW follows, and each TW repeats the T3 outputs.
- R7: Kind codes are 2'b00 read, 2'b01 write, 2'b10 interrupt acknowledge, and 2'b11 treated as a read. A request is taken at the end of the first half of an idle state or of T4, and `req_accept` is high for the following half. In that half `m_io` becomes 1 for a memory read or write (`req_io`=0) and 0 for an IO or interrupt-acknowledge cycle. In the same half `dt_r` becomes 1 for a write and 0 otherwise. Both hold their values until that point in the next cycle's T4 or idle state. T1 follows immediately.
- R8: `hold` is sampled at the same decision point as requests and takes priority over them. The block then passes through one T1-length hold-entry state. In its second half `hlda` rises while `ctl_oe` and `ad_oe` are low. `ale` stays a driven low.
- R9: While `hlda` is high, no request is taken. Once `hold` is sampled low at the end of a second half, `hlda` falls, `ctl_oe` returns high, and a pending request is taken at the next decision point.
- R10: For read and interrupt-acknowledge cycles, `ad_in` is captured at the end of the final T3/TW. `rd_valid` is high for the first half of T4 with that value on `rd_data`. `rd_valid` stays low for writes.
- R11: While `rst` is high the block is idle: `ale`, `ad_oe`, `hlda`, `req_accept` and `rd_valid` are low, `wr_n`, `inta_n` and `den_n` are high, and `ctl_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus T-state rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Cycle request pending |
| req_kind | input | 2 | Cycle kind code |
| req_io | input | 1 | 1 selects IO space, 0 memory |
| req_addr | input | W | Cycle address |
| req_wdata | input | W | Write data |
| ready | input | 1 | High ends wait states |
| hold | input | 1 | Bus request from another master |
| ad_in | input | W | Shared bus as seen by the receiver |
| ad_out | output | W | Shared bus drive value |
| ad_oe | output | 1 | Shared bus output enable |
| ale | output | 1 | Address latch strobe |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt-acknowledge strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| dt_r | output | 1 | Transceiver direction, 1 = transmit |
| m_io | output | 1 | 1 = memory, 0 = IO |
| ctl_oe | output | 1 | Output enable for the control lines |
| hlda | output | 1 | Hold acknowledge |
| req_accept | output | 1 | Request taken this half |
| rd_data | output | W | Captured read data |
| rd_valid | output | 1 | Read data valid |

## Verification
The hardest situations to reach are the decision point inside T4 of a running cycle and a hold request that arrives together with a pending request. Reaching the first one needs a new request raised in the first half of T4. The bench raises it at that slot while walking a cycle, then checks that `m_io` and `dt_r` switch while the old cycle is still in T4 and that T1 follows with no idle state between. For the hold case the bench raises `hold` and `req_valid` in the same idle half. It confirms that the acknowledge wins, that no request is taken while held, and that the queued request is taken once hold is released.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    S_TI, S_T1, S_T2, S_T3, S_TW, S_T4, S_TH, S_HD
  } tstate_e;

  typedef enum logic [1:0] {
    K_READ  = 2'b00,
    K_WRITE = 2'b01,
    K_INTA  = 2'b10,
    K_RSV   = 2'b11
  } kind_e;
endpackage

// File: rtl/bcs_seq.sv
module bcs_seq
  import bcs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  input  logic [1:0]   req_kind,
  input  logic         req_io,
  input  logic [W-1:0] req_addr,
  input  logic [W-1:0] req_wdata,
  input  logic         ready,
  input  logic         hold,
  input  logic [W-1:0] ad_in,
  output tstate_e      st_d,
  output logic         ph_d,
  output kind_e        kind_d,
  output logic [W-1:0] pend_addr,
  output logic [W-1:0] cur_wdata,
  output logic         m_io,
  output logic         dt_r,
  output logic         req_accept,
  output logic [W-1:0] rd_data,
  output logic         rd_valid
);
  tstate_e      st_q;
  logic         ph_q;
  kind_e        cyc_kind_q, pend_kind_q, kind_in;
  logic [W-1:0] pend_wdata_q;
  logic         go_hold_q, go_cyc_q;
  logic         decide, take, enter_t1, last_wait;

  // decision point: end of first half of an idle state or of T4
  assign decide    = !ph_q && (st_q == S_TI || st_q == S_T4);
  assign take      = decide && !hold && req_valid;
  assign kind_in   = (req_kind == 2'b11) ? K_READ : kind_e'(req_kind);
  assign enter_t1  = (st_d == S_T1) && (st_q != S_T1);
  assign last_wait = ph_q && (st_q == S_T3 || st_q == S_TW) && ready;
  assign kind_d    = enter_t1 ? pend_kind_q : cyc_kind_q;

  always_comb begin
    st_d = st_q;
    ph_d = ~ph_q;
    if (ph_q) begin
      case (st_q)
        S_TI, S_T4: st_d = go_hold_q ? S_TH : (go_cyc_q ? S_T1 : S_TI);
        S_T1:       st_d = S_T2;
        S_T2:       st_d = S_T3;
        S_T3, S_TW: st_d = ready ? S_T4 : S_TW;
        S_TH:       st_d = S_HD;
        S_HD:       st_d = hold ? S_HD : S_TI;
        default:    st_d = S_TI;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= S_TI;
      ph_q         <= 1'b0;
      cyc_kind_q   <= K_READ;
      pend_kind_q  <= K_READ;
      pend_addr    <= '0;
      pend_wdata_q <= '0;
      cur_wdata    <= '0;
      go_hold_q    <= 1'b0;
      go_cyc_q     <= 1'b0;
      m_io         <= 1'b0;
      dt_r         <= 1'b0;
      req_accept   <= 1'b0;
      rd_data      <= '0;
      rd_valid     <= 1'b0;
    end else begin
      st_q       <= st_d;
      ph_q       <= ph_d;
      cyc_kind_q <= kind_d;
      req_accept <= take;
      if (decide) begin
        go_hold_q <= hold;
        go_cyc_q  <= take;
      end else if (ph_q) begin
        go_hold_q <= 1'b0;
        go_cyc_q  <= 1'b0;
      end
      if (take) begin
        pend_kind_q  <= kind_in;
        pend_addr    <= req_addr;
        pend_wdata_q <= req_wdata;
        m_io         <= !(req_io || kind_in == K_INTA);
        dt_r         <= (kind_in == K_WRITE);
      end
      if (enter_t1) cur_wdata <= pend_wdata_q;
      rd_valid <= last_wait && (cyc_kind_q != K_WRITE);
      if (last_wait && cyc_kind_q != K_WRITE) rd_data <= ad_in;
    end
  end

  assert_t1_to_t2_R1: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_T1 && ph_q) |=> (st_q == S_T2));

  assert_wait_after_t3_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_TW && !ph_q) |-> ($past(st_q) == S_T3 || $past(st_q) == S_TW));

  assert_no_take_in_hold_R8: assert property (@(posedge clk) disable iff (rst)
    req_accept |-> !$past(hold));

  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_HD && ph_q && !hold) |=> (st_q == S_TI));
endmodule

// File: rtl/bcs_drive.sv
module bcs_drive
  import bcs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  tstate_e      st_d,
  input  logic         ph_d,
  input  kind_e        kind_d,
  input  logic [W-1:0] pend_addr,
  input  logic [W-1:0] cur_wdata,
  output logic [W-1:0] ad_out,
  output logic         ad_oe,
  output logic         ale,
  output logic         wr_n,
  output logic         inta_n,
  output logic         den_n,
  output logic         hlda,
  output logic         ctl_oe
);
  logic strobe_st, data_st, t4_first, is_wr, is_ia, den_on, hl_on;

  assign strobe_st = (st_d == S_T2) || (st_d == S_T3) || (st_d == S_TW);
  assign data_st   = strobe_st || (st_d == S_T4);
  assign t4_first  = (st_d == S_T4) && !ph_d;
  assign is_wr     = (kind_d == K_WRITE);
  assign is_ia     = (kind_d == K_INTA);
  assign hl_on     = ((st_d == S_TH) && ph_d) || (st_d == S_HD);

  always_comb begin
    if (is_wr) den_on = strobe_st || t4_first;
    else       den_on = ((st_d == S_T2) && ph_d) || (st_d == S_T3)
                        || (st_d == S_TW) || t4_first;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out <= '0;
      ad_oe  <= 1'b0;
      ale    <= 1'b0;
      wr_n   <= 1'b1;
      inta_n <= 1'b1;
      den_n  <= 1'b1;
      hlda   <= 1'b0;
      ctl_oe <= 1'b1;
    end else begin
      ad_out <= (st_d == S_T1) ? pend_addr : cur_wdata;
      ad_oe  <= (st_d == S_T1) || (is_wr && data_st);
      ale    <= (st_d == S_T1);
      wr_n   <= !(is_wr && strobe_st);
      inta_n <= !(is_ia && strobe_st);
      den_n  <= !den_on;
      hlda   <= hl_on;
      ctl_oe <= !hl_on;
    end
  end

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    !(!wr_n && !inta_n));

  assert_float_with_ack_R8: assert property (@(posedge clk) disable iff (rst)
    hlda |-> (!ad_oe && !ctl_oe && !ale));

  assert_ale_drives_addr_R1: assert property (@(posedge clk) disable iff (rst)
    ale |-> ad_oe);

  assert_write_inside_den_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> !den_n);
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  input  logic [1:0]   req_kind,
  input  logic         req_io,
  input  logic [W-1:0] req_addr,
  input  logic [W-1:0] req_wdata,
  input  logic         ready,
  input  logic         hold,
  input  logic [W-1:0] ad_in,
  output logic [W-1:0] ad_out,
  output logic         ad_oe,
  output logic         ale,
  output logic         wr_n,
  output logic         inta_n,
  output logic         den_n,
  output logic         dt_r,
  output logic         m_io,
  output logic         ctl_oe,
  output logic         hlda,
  output logic         req_accept,
  output logic [W-1:0] rd_data,
  output logic         rd_valid
);
  tstate_e      st_d;
  logic         ph_d;
  kind_e        kind_d;
  logic [W-1:0] pend_addr, cur_wdata;

  bcs_seq #(.W(W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(ready), .hold(hold), .ad_in(ad_in),
    .st_d(st_d), .ph_d(ph_d), .kind_d(kind_d),
    .pend_addr(pend_addr), .cur_wdata(cur_wdata),
    .m_io(m_io), .dt_r(dt_r), .req_accept(req_accept),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  bcs_drive #(.W(W)) u_drive (
    .clk(clk), .rst(rst), .st_d(st_d), .ph_d(ph_d), .kind_d(kind_d),
    .pend_addr(pend_addr), .cur_wdata(cur_wdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale), .wr_n(wr_n),
    .inta_n(inta_n), .den_n(den_n), .hlda(hlda), .ctl_oe(ctl_oe)
  );
endmodule

// File: tb/sim_bus_cycle_seq.sv
module sim_bus_cycle_seq;
  localparam int W = 16;
  localparam int NV = 7;
  // {kind[36:35], io[34], waits[33:32], addr[31:16], data[15:0]}
  localparam logic [36:0] VEC [NV] = '{
    {2'b00, 1'b0, 2'd0, 16'h1234, 16'hA5C3},
    {2'b00, 1'b1, 2'd2, 16'h0042, 16'h5A3C},
    {2'b01, 1'b0, 2'd0, 16'hBEEF, 16'h1357},
    {2'b01, 1'b1, 2'd2, 16'h00F0, 16'h2468},
    {2'b10, 1'b0, 2'd0, 16'h0000, 16'h0021},
    {2'b10, 1'b0, 2'd2, 16'h0000, 16'h0077},
    {2'b11, 1'b0, 2'd0, 16'h7E7E, 16'hC0DE}
  };

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_io = 0, ready = 1, hold = 0;
  logic [1:0] req_kind = 0;
  logic [W-1:0] req_addr = 0, req_wdata = 0, ad_in = 0;
  logic [W-1:0] ad_out, rd_data;
  logic ad_oe, ale, wr_n, inta_n, den_n, dt_r, m_io, ctl_oe, hlda, req_accept, rd_valid;
  int nvec = 0, nfail = 0;

  always #10ns clk = ~clk;

  bus_cycle_seq #(.W(W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(ready), .hold(hold), .ad_in(ad_in), .ad_out(ad_out),
    .ad_oe(ad_oe), .ale(ale), .wr_n(wr_n), .inta_n(inta_n), .den_n(den_n),
    .dt_r(dt_r), .m_io(m_io), .ctl_oe(ctl_oe), .hlda(hlda),
    .req_accept(req_accept), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic io,
                       input logic [15:0] a, input logic [15:0] d);
    bit seen = 0;
    req_kind = k; req_io = io; req_addr = a; req_wdata = d; req_valid = 1;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (req_accept) seen = 1;
    end
    chk("R7", "request taken", seen, 1);
    chk("R7", "m_io", m_io, !(io || k == 2'b10));
    chk("R7", "dt_r", dt_r, k == 2'b01);
    req_valid = 0;
  endtask

  // walks T1..T4 after the accept half; 0=T1 1=T2 2=T3 3=TW 4=T4
  task automatic walk(input logic [1:0] k, input int w, input logic [15:0] a,
                      input logic [15:0] d, input bit chain, input logic [1:0] nk,
                      input logic nio, input logic [15:0] na, input logic [15:0] nd);
    int tw_seen = 0;
    bit wr = (k == 2'b01);
    bit ia = (k == 2'b10);
    ad_in = d;
    for (int i = 0; i < 8 + 2 * w; i++) begin
      int s, p;
      bit mid, den_exp;
      string tg;
      p = i % 2;
      if (i < 2) s = 0; else if (i < 4) s = 1; else if (i < 6) s = 2;
      else if (i < 6 + 2 * w) s = 3; else s = 4;
      @(negedge clk);
      mid = (s >= 1 && s <= 3);
      if (wr) den_exp = mid || (s == 4 && p == 0);
      else den_exp = (s == 1 && p == 1) || s == 2 || s == 3 || (s == 4 && p == 0);
      chk("R1", "ale", ale, s == 0);
      chk((s == 3) ? "R6" : "R2", "ad_oe", ad_oe, s == 0 || wr);
      if (s == 0) chk("R1", "address", ad_out, a);
      else if (wr) chk("R2", "write data", ad_out, d);
      chk((s == 3) ? "R6" : "R3", "wr_n", wr_n, !(wr && mid));
      chk((s == 3) ? "R6" : "R4", "inta_n", inta_n, !(ia && mid));
      chk((s == 3) ? "R6" : "R5", "den_n", den_n, !den_exp);
      if (s == 4 && p == 0) begin
        chk("R10", "rd_valid", rd_valid, !wr);
        if (!wr) chk("R10", "rd_data", rd_data, d);
      end
      if (s == 3 && p == 1) tw_seen++;
      ready = (tw_seen >= w);
      if (chain && s == 4 && p == 0) begin
        req_kind = nk; req_io = nio; req_addr = na; req_wdata = nd; req_valid = 1;
      end
    end
  endtask

  initial begin
    #(20ns * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "ale", ale, 0);
    chk("R11", "ad_oe", ad_oe, 0);
    chk("R11", "wr_n", wr_n, 1);
    chk("R11", "inta_n", inta_n, 1);
    chk("R11", "den_n", den_n, 1);
    chk("R11", "hlda", hlda, 0);
    chk("R11", "ctl_oe", ctl_oe, 1);
    chk("R11", "rd_valid", rd_valid, 0);
    rst = 0;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      issue(VEC[v][36:35], VEC[v][34], VEC[v][31:16], VEC[v][15:0]);
      walk(VEC[v][36:35], int'(VEC[v][33:32]), VEC[v][31:16], VEC[v][15:0],
           0, 2'b00, 0, 16'h0, 16'h0);
      ready = 1;
      @(negedge clk);
      chk("R2", "idle ad_oe", ad_oe, 0);
      chk("R5", "idle den_n", den_n, 1);
      chk("R1", "idle ale", ale, 0);
    end

    // back-to-back: new request taken in T4 of a memory read
    issue(2'b00, 0, 16'h3000, 16'h4444);
    walk(2'b00, 0, 16'h3000, 16'h4444, 1, 2'b01, 1, 16'h3002, 16'h9999);
    chk("R7", "accept in T4", req_accept, 1);
    chk("R7", "dt_r switched in T4", dt_r, 1);
    chk("R7", "m_io switched in T4", m_io, 0);
    req_valid = 0;
    walk(2'b01, 0, 16'h3002, 16'h9999, 0, 2'b00, 0, 16'h0, 16'h0);
    @(negedge clk);

    // hold together with a pending request
    begin
      bit prev_ctl = 1, rose = 0, taken = 0;
      hold = 1;
      req_kind = 2'b01; req_io = 0; req_addr = 16'h0ABC; req_wdata = 16'h1111;
      req_valid = 1;
      for (int i = 0; i < 12 && !rose; i++) begin
        @(negedge clk);
        if (req_accept) taken = 1;
        if (hlda) begin
          rose = 1;
          chk("R8", "ctl_oe before ack", prev_ctl, 1);
          chk("R8", "ctl_oe floats with ack", ctl_oe, 0);
          chk("R8", "ad_oe floats with ack", ad_oe, 0);
          chk("R8", "ale driven low", ale, 0);
        end
        prev_ctl = ctl_oe;
      end
      chk("R8", "hlda raised", rose, 1);
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (req_accept) taken = 1;
      end
      chk("R9", "hlda held", hlda, 1);
      chk("R8", "hold beats request", taken, 0);
      hold = 0;
      rose = 0;
      for (int i = 0; i < 6 && !rose; i++) begin
        @(negedge clk);
        if (!hlda) rose = 1;
      end
      chk("R9", "hlda dropped", rose, 1);
      chk("R9", "ctl_oe restored", ctl_oe, 1);
      for (int i = 0; i < 6 && !taken; i++) begin
        @(negedge clk);
        if (req_accept) taken = 1;
      end
      chk("R9", "request taken after release", taken, 1);
      req_valid = 0;
      walk(2'b01, 0, 16'h0ABC, 16'h1111, 0, 2'b00, 0, 16'h0, 16'h0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule